// File: doc/BRIEF.md
# Conditional Select Execute Unit

This block decodes and executes one 32-bit conditional-select instruction word per clock. It covers four operations: plain select, select-increment, select-invert and select-negate. The word names two source registers. The block drives their indices out to a register file and takes the two read values back. It evaluates a 4-bit condition code against the N, Z, C and V flags. If the condition holds, the result is the first source. If not, the result is the second source passed through the operation's function.

The result, destination index and write enable are registered, together with a class code and a reported condition. The class code tells a tracer or disassembler which preferred alias the word stands for: a set-flag form, a set-mask form, a single-register increment, invert or negate form, or the base form. The block also flags undefined and unpredictable encodings, and it flags words that are not part of the family at all. Register index 15 reads as zero.

Top module: `cond_sel_unit`

## Requirements
- R1: A word belongs to the family when bits [31:20] are 0xEA5 and bits [15:12] are 8, 9, 0xA or 0xB. Any other word gives nomatch_o=1, wr_en_o=0, undef_o=0, unpred_o=0 and class 15.
- R2: Bits [19:16] give the first source and drive rd_a_idx_o. Bits [3:0] give the second source and drive rd_b_idx_o. Bits [11:8] give the destination, reported on wr_idx_o. Bits [7:4] give the condition.
- R3: Bits [15:12] select the operation: 8 select, 9 increment, 0xA invert, 0xB negate. A true condition yields the first source. A false condition yields the second source unchanged, plus one, bitwise NOT, or two's-complement negated, in that order, all modulo 2^32.
- R4: A source index of 15 supplies zero instead of the register read value.
- R5: Condition codes 0 to 13 follow the usual pairs, each odd code being the inverse of the even code below it: 0 Z, 2 C, 4 N, 6 V, 8 C and not Z, 10 N equal to V, 12 not Z and N equal to V. Codes 14 and 15 are always true. Flags enter as nzcv_i = {N,Z,C,V}.
- R6: A second-source index of 13 is undefined: undef_o=1 and wr_en_o=0.
- R7: A destination index of 13 or 15 raises unpred_o. The write still takes place.
- R8: If both sources are 15 and the operation is increment, the class is 4. If both sources are 15 and the operation is invert, the class is 5. In both cases cond_o is the encoded condition with bit 0 flipped.
- R9: If the two sources are equal and not 15, the class is 6 for increment, 7 for invert and 8 for negate, with cond_o flipped in bit 0. Plain select is never aliased, and negate with both sources 15 keeps its base class.
- R10: Any other matched word gets its base class: 0 select, 1 increment, 2 invert, 3 negate. cond_o equals the encoded condition.
- R11: The result, write index, write enable, class, reported condition and flags appear one clock after the word is presented. A synchronous active-high reset forces wr_en_o, undef_o, unpred_o and nomatch_o to 0 and the class to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| nzcv_i | input | 4 | Flags {N,Z,C,V} |
| rd_a_val_i | input | DATA_W | Read value for the first source |
| rd_b_val_i | input | DATA_W | Read value for the second source |
| rd_a_idx_o | output | 4 | First source read index |
| rd_b_idx_o | output | 4 | Second source read index |
| res_o | output | DATA_W | Registered result |
| wr_idx_o | output | 4 | Registered destination index |
| wr_en_o | output | 1 | Registered write enable |
| cls_o | output | 4 | Registered alias class code |
| cond_o | output | 4 | Registered reported condition |
| undef_o | output | 1 | Undefined encoding flag |
| unpred_o | output | 1 | Unpredictable destination flag |
| nomatch_o | output | 1 | Word is outside the family |

## Verification
The bench builds the unit with the default DATA_W of 32. At that width the ±1 and negate paths wrap exactly at 2^32: incrementing a register that holds all ones gives zero, and negating zero through the index-15 source gives zero. The bench keeps a 16-entry register file model and writes results back into it, so earlier results feed later words. A sweep of all 16 conditions against all 16 flag patterns covers every condition code.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 4;
  localparam int CC_W   = 4;
  localparam logic [11:0] OPC_HI  = 12'hEA5;
  localparam logic [IDX_W-1:0] IDX_ZR = 4'd15;
  localparam logic [IDX_W-1:0] IDX_SP = 4'd13;

  typedef enum logic [1:0] {
    OP_SEL = 2'd0,
    OP_INC = 2'd1,
    OP_INV = 2'd2,
    OP_NEG = 2'd3
  } csel_op_e;

  typedef enum logic [3:0] {
    CLS_CSEL  = 4'd0,
    CLS_CSINC = 4'd1,
    CLS_CSINV = 4'd2,
    CLS_CSNEG = 4'd3,
    CLS_CSET  = 4'd4,
    CLS_CSETM = 4'd5,
    CLS_CINC  = 4'd6,
    CLS_CINV  = 4'd7,
    CLS_CNEG  = 4'd8,
    CLS_NONE  = 4'd15
  } csel_cls_e;
endpackage

// File: rtl/csel_decode.sv
module csel_decode
  import csel_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic              hit,
  output csel_op_e          op,
  output logic [IDX_W-1:0]  rd,
  output logic [IDX_W-1:0]  rn,
  output logic [IDX_W-1:0]  rm,
  output logic [CC_W-1:0]   cond_raw,
  output csel_cls_e         cls,
  output logic [CC_W-1:0]   cond_rep,
  output logic              undef,
  output logic              unpred
);
  logic both_zr, same_src, aliased;

  assign hit      = (insn[31:20] == OPC_HI) && (insn[15:14] == 2'b10);
  assign op       = csel_op_e'(insn[13:12]);
  assign rn       = insn[19:16];
  assign rd       = insn[11:8];
  assign cond_raw = insn[7:4];
  assign rm       = insn[3:0];

  assign both_zr  = (rn == IDX_ZR) && (rm == IDX_ZR);
  assign same_src = (rn == rm) && (rn != IDX_ZR);

  always_comb begin
    cls = CLS_NONE;
    if (hit) begin
      unique case (op)
        OP_SEL: cls = CLS_CSEL;
        OP_INC: cls = both_zr ? CLS_CSET  : (same_src ? CLS_CINC : CLS_CSINC);
        OP_INV: cls = both_zr ? CLS_CSETM : (same_src ? CLS_CINV : CLS_CSINV);
        OP_NEG: cls = same_src ? CLS_CNEG : CLS_CSNEG;
        default: cls = CLS_NONE;
      endcase
    end
  end

  assign aliased  = (cls == CLS_CSET) || (cls == CLS_CSETM) || (cls == CLS_CINC) ||
                    (cls == CLS_CINV) || (cls == CLS_CNEG);
  assign cond_rep = !hit ? '0 : (aliased ? {cond_raw[CC_W-1:1], ~cond_raw[0]} : cond_raw);
  assign undef    = hit && (rm == IDX_SP);
  assign unpred   = hit && ((rd == IDX_SP) || (rd == IDX_ZR));
endmodule

// File: rtl/csel_cond.sv
module csel_cond
  import csel_pkg::*;
(
  input  logic [CC_W-1:0] cc,
  input  logic [3:0]      nzcv,
  output logic            pass
);
  logic n, z, c, v;
  assign {n, z, c, v} = nzcv;

  always_comb begin
    unique case (cc)
      4'd0:  pass = z;
      4'd1:  pass = !z;
      4'd2:  pass = c;
      4'd3:  pass = !c;
      4'd4:  pass = n;
      4'd5:  pass = !n;
      4'd6:  pass = v;
      4'd7:  pass = !v;
      4'd8:  pass = c && !z;
      4'd9:  pass = !c || z;
      4'd10: pass = (n == v);
      4'd11: pass = (n != v);
      4'd12: pass = !z && (n == v);
      4'd13: pass = z || (n != v);
      default: pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  csel_op_e          op,
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] b_val,
  input  logic              a_zr,
  input  logic              b_zr,
  input  logic              take_a,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] a_eff, b_eff, b_fn;

  assign a_eff = a_zr ? '0 : a_val;
  assign b_eff = b_zr ? '0 : b_val;

  always_comb begin
    unique case (op)
      OP_SEL:  b_fn = b_eff;
      OP_INC:  b_fn = b_eff + DATA_W'(1);
      OP_INV:  b_fn = ~b_eff;
      OP_NEG:  b_fn = '0 - b_eff;
      default: b_fn = b_eff;
    endcase
  end

  assign result = take_a ? a_eff : b_fn;
endmodule

// File: rtl/cond_sel_unit.sv
module cond_sel_unit
  import csel_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       insn_i,
  input  logic [3:0]        nzcv_i,
  input  logic [DATA_W-1:0] rd_a_val_i,
  input  logic [DATA_W-1:0] rd_b_val_i,
  output logic [3:0]        rd_a_idx_o,
  output logic [3:0]        rd_b_idx_o,
  output logic [DATA_W-1:0] res_o,
  output logic [3:0]        wr_idx_o,
  output logic              wr_en_o,
  output logic [3:0]        cls_o,
  output logic [3:0]        cond_o,
  output logic              undef_o,
  output logic              unpred_o,
  output logic              nomatch_o
);
  logic              hit, undef, unpred, pass;
  csel_op_e          op;
  csel_cls_e         cls;
  logic [IDX_W-1:0]  rd, rn, rm;
  logic [CC_W-1:0]   cond_raw, cond_rep;
  logic [DATA_W-1:0] result;

  csel_decode u_dec (
    .insn(insn_i), .hit(hit), .op(op), .rd(rd), .rn(rn), .rm(rm),
    .cond_raw(cond_raw), .cls(cls), .cond_rep(cond_rep),
    .undef(undef), .unpred(unpred)
  );

  csel_cond u_cc (.cc(cond_raw), .nzcv(nzcv_i), .pass(pass));

  csel_datapath #(.DATA_W(DATA_W)) u_dp (
    .op(op), .a_val(rd_a_val_i), .b_val(rd_b_val_i),
    .a_zr(rn == IDX_ZR), .b_zr(rm == IDX_ZR),
    .take_a(pass), .result(result)
  );

  assign rd_a_idx_o = rn;
  assign rd_b_idx_o = rm;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      wr_idx_o  <= '0;
      wr_en_o   <= 1'b0;
      cls_o     <= CLS_NONE;
      cond_o    <= '0;
      undef_o   <= 1'b0;
      unpred_o  <= 1'b0;
      nomatch_o <= 1'b0;
    end else begin
      res_o     <= result;
      wr_idx_o  <= rd;
      wr_en_o   <= hit && !undef;
      cls_o     <= cls;
      cond_o    <= cond_rep;
      undef_o   <= undef;
      unpred_o  <= unpred;
      nomatch_o <= !hit;
    end
  end
endmodule

// File: rtl/cond_sel_unit_checker.sv
module cond_sel_unit_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       insn_i,
  input logic [DATA_W-1:0] res_o,
  input logic              wr_en_o,
  input logic [3:0]        cls_o,
  input logic [3:0]        cond_o,
  input logic              undef_o,
  input logic              unpred_o,
  input logic              nomatch_o
);
  logic fam;
  assign fam = (insn_i[31:20] == 12'hEA5) && (insn_i[15:14] == 2'b10);

  a_r6_undef_no_write: assert property (@(posedge clk) disable iff (rst)
    undef_o |-> !wr_en_o);

  a_r1_nomatch_quiet: assert property (@(posedge clk) disable iff (rst)
    nomatch_o |-> (!undef_o && !wr_en_o && !unpred_o));

  a_r6_sp_source: assert property (@(posedge clk) disable iff (rst)
    (fam && insn_i[3:0] == 4'd13) |=> (undef_o && !wr_en_o));

  a_r7_bad_dest: assert property (@(posedge clk) disable iff (rst)
    (fam && (insn_i[11:8] == 4'd13 || insn_i[11:8] == 4'd15)) |=> unpred_o);

  a_r8_cset_flip: assert property (@(posedge clk) disable iff (rst)
    (fam && insn_i[19:16] == 4'd15 && insn_i[3:0] == 4'd15 && insn_i[15:12] == 4'h9)
    |=> (cls_o == 4'd4 && cond_o == ($past(insn_i[7:4]) ^ 4'd1)));

  a_r4_zero_pair: assert property (@(posedge clk) disable iff (rst)
    (fam && insn_i[19:16] == 4'd15 && insn_i[3:0] == 4'd15 && insn_i[15:12] == 4'h8)
    |=> (res_o == '0));
endmodule

bind cond_sel_unit cond_sel_unit_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .insn_i(insn_i), .res_o(res_o), .wr_en_o(wr_en_o),
  .cls_o(cls_o), .cond_o(cond_o), .undef_o(undef_o), .unpred_o(unpred_o),
  .nomatch_o(nomatch_o)
);

// File: tb/sim_cond_sel_unit.sv
`timescale 1ns/1ps
module sim_cond_sel_unit;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [31:0]   insn;
  logic [3:0]    nzcv;
  logic [DW-1:0] a_val, b_val, res;
  logic [3:0]    a_idx, b_idx, wr_idx, cls, cond;
  logic          wr_en, undef, unpred, nomatch;
  logic [DW-1:0] regs [16];
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign a_val = regs[a_idx];
  assign b_val = regs[b_idx];

  cond_sel_unit #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .insn_i(insn), .nzcv_i(nzcv),
    .rd_a_val_i(a_val), .rd_b_val_i(b_val),
    .rd_a_idx_o(a_idx), .rd_b_idx_o(b_idx), .res_o(res),
    .wr_idx_o(wr_idx), .wr_en_o(wr_en), .cls_o(cls), .cond_o(cond),
    .undef_o(undef), .unpred_o(unpred), .nomatch_o(nomatch)
  );

  typedef struct packed {
    logic [31:0] w;
    logic [3:0]  f;
    logic [31:0] r;
    logic [3:0]  k;
    logic [3:0]  c;
    logic        we, ud, up, nm;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{32'hEA5293A2, 4'h0, 32'h22222222, 4'd6,  4'hB, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA5293A2, 4'h8, 32'h22222223, 4'd6,  4'hB, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA52B3B4, 4'h0, 32'hBBBBBBBC, 4'd3,  4'hB, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA54A3B4, 4'h8, 32'h44444444, 4'd7,  4'hA, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA54A3B4, 4'h0, 32'hBBBBBBBB, 4'd7,  4'hA, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA568507, 4'h4, 32'h66666666, 4'd0,  4'h0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA568507, 4'h0, 32'h77777777, 4'd0,  4'h0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA5F9887, 4'h2, 32'h00000000, 4'd1,  4'h8, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA56A9EF, 4'h0, 32'h66666666, 4'd2,  4'hE, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA56BA0F, 4'h0, 32'h00000000, 4'd3,  4'h0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA5FAB0F, 4'h0, 32'hFFFFFFFF, 4'd5,  4'h1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA529C0B, 4'h0, 32'h00000000, 4'd1,  4'h0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA5F940F, 4'h0, 32'h00000001, 4'd4,  4'h1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA52860D, 4'h0, 32'h00000000, 4'd0,  4'h0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'hEA528D05, 4'h4, 32'h22222222, 4'd0,  4'h0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'hEA52C305, 4'h0, 32'h00000000, 4'd15, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'hEB528305, 4'h0, 32'h00000000, 4'd15, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'hEA569CD7, 4'h1, 32'h66666666, 4'd1,  4'hD, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA5FBC0F, 4'h0, 32'h00000000, 4'd3,  4'h0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'hEA5F9F0F, 4'h4, 32'h00000000, 4'd4,  4'h1, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic cc_holds(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v, r;
    {n, z, cy, v} = f;
    case (c[3:1])
      3'd0: r = z;
      3'd1: r = cy;
      3'd2: r = n;
      3'd3: r = v;
      3'd4: r = cy && !z;
      3'd5: r = (n == v);
      3'd6: r = !z && (n == v);
      default: r = 1'b1;
    endcase
    if (c[0] && c[3:1] != 3'd7) r = !r;
    return r;
  endfunction

  function automatic string cls_req(input logic [3:0] k);
    if (k == 4'd4 || k == 4'd5) return "R8";
    if (k >= 4'd6 && k <= 4'd8) return "R9";
    if (k == 4'd15) return "R1";
    return "R10";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h11111111 * i;
    rst  = 1'b1;
    insn = 32'hEA568507;
    nzcv = 4'h4;
    repeat (3) @(negedge clk);
    // R11: reset state while a valid word is presented
    chk("R11", "wr_en in reset", {31'd0, wr_en}, 32'd0);
    chk("R11", "nomatch in reset", {31'd0, nomatch}, 32'd0);
    chk("R11", "undef in reset", {31'd0, undef}, 32'd0);
    chk("R11", "class in reset", {28'd0, cls}, 32'd15);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      insn = TBL[i].w;
      nzcv = TBL[i].f;
      #1;
      chk("R2", "first read index", {28'd0, a_idx}, {28'd0, TBL[i].w[19:16]});
      chk("R2", "second read index", {28'd0, b_idx}, {28'd0, TBL[i].w[3:0]});
      @(negedge clk);
      if (TBL[i].we) begin
        if (TBL[i].w[19:16] == 4'd15 || TBL[i].w[3:0] == 4'd15)
          chk("R4", $sformatf("result row %0d", i), res, TBL[i].r);
        else
          chk("R3", $sformatf("result row %0d", i), res, TBL[i].r);
        chk("R2", "write index", {28'd0, wr_idx}, {28'd0, TBL[i].w[11:8]});
      end
      chk(cls_req(TBL[i].k), $sformatf("class row %0d", i), {28'd0, cls}, {28'd0, TBL[i].k});
      chk(cls_req(TBL[i].k), $sformatf("cond row %0d", i), {28'd0, cond}, {28'd0, TBL[i].c});
      chk("R6", $sformatf("wr_en row %0d", i), {31'd0, wr_en}, {31'd0, TBL[i].we});
      chk("R6", $sformatf("undef row %0d", i), {31'd0, undef}, {31'd0, TBL[i].ud});
      chk("R7", $sformatf("unpred row %0d", i), {31'd0, unpred}, {31'd0, TBL[i].up});
      chk("R1", $sformatf("nomatch row %0d", i), {31'd0, nomatch}, {31'd0, TBL[i].nm});
      if (wr_en) regs[wr_idx] = res;
    end

    // R5: every condition against every flag pattern, select r6 or r7 into r5
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        insn = {12'hEA5, 4'h6, 4'h8, 4'h5, 4'(c), 4'h7};
        nzcv = 4'(f);
        @(negedge clk);
        chk("R5", $sformatf("cond %0d flags %h", c, f), res,
            cc_holds(4'(c), 4'(f)) ? regs[6] : regs[7]);
        if (wr_en) regs[wr_idx] = res;
      end
    end

    // R11: one-cycle latency, then reset asserted mid-stream
    insn = 32'hEA568507;
    nzcv = 4'h0;
    @(negedge clk);
    insn = 32'hEA568507;
    nzcv = 4'h4;
    @(posedge clk);
    #1;
    chk("R11", "result just after edge", res, 32'h66666666);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R11", "wr_en after mid reset", {31'd0, wr_en}, 32'd0);
    chk("R11", "class after mid reset", {28'd0, cls}, 32'd15);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "wr_en after release", {31'd0, wr_en}, 32'd1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule